// File: doc/BRIEF.md
# I2C Command Target with Status-First Readout

This block is the two-wire serial target for a data-decoder peripheral. A bus master addresses it at 28h to write a command. Depending on the command code, that command is either a single command byte or a command byte followed by one data byte. Once a command is complete, the block raises a single-cycle strobe toward the core. The strobe carries the command code and its data byte. The block then lowers its ready flag until the core reports that it is idle again.

Reads use address 29h. Every read first returns a status byte that holds a ready flag, a data-available flag and a pair flag. Any data bytes the core has staged follow the status byte. The core stages one or two bytes with a load pulse. The data-available flag drops only once the last staged byte has been shifted out completely. The master therefore reads the status byte, checks the flags, and then collects the bytes in a later read.

SCL and SDA are oversampled in the system clock domain. The bus controller is one state machine with six states:
- `ST_IDLE`: disengaged.
- `ST_ADDR`: shifting in the address byte.
- `ST_ACK`: the target's acknowledge slot.
- `ST_WRX`: shifting in a command or data byte.
- `ST_TX`: shifting out a byte.
- `ST_MACK`: the master's acknowledge slot.

The state transitions are:
- A start or repeated start takes any state to `ST_ADDR`.
- A stop takes any state to `ST_IDLE`.
- From `ST_ADDR`, the eighth address bit leads to `ST_ACK` on an address match and to `ST_IDLE` otherwise.
- `ST_ACK` leads to `ST_TX` for a read. For a write it leads to `ST_WRX` if more bytes are due, and to `ST_IDLE` once the command is complete.
- `ST_WRX` returns to `ST_ACK` after eight bits.
- `ST_TX` moves to `ST_MACK` after eight bits.
- `ST_MACK` returns to `ST_TX` on a master ACK and goes to `ST_IDLE` on a NACK.

Top module: `i2c_cmd_target`

## Requirements
- R1: After reset SDA is released, no command strobe is raised, and a status read returns 80h.
- R2: Only address byte 28h (write) and 29h (read) are acknowledged. Any other address gets no acknowledge, causes no strobe, and every following byte up to the next start is ignored.
- R3: A command code with bit 7 set is acknowledged together with one data byte. Any other code is acknowledged alone. Bytes sent beyond that count are not acknowledged.
- R4: A completed command raises `cmd_valid_o` for exactly one clock cycle, with the code on `cmd_code_o` and the data byte on `cmd_data_o`. The data output is 00h for a one-byte command.
- R5: Status bit 7 (ready) is 0 from the cycle after a command strobe until `core_idle_i` is seen high. It is 1 otherwise.
- R6: Every read begins with the status byte. Bit 7 is ready, bit 6 is data-available, bit 5 is pair, and bits 4:0 are zero.
- R7: A `load_i` pulse stages `load_b0_i`, and `load_b1_i` as well when `load_two_i` is high. It sets data-available, and it sets pair exactly when two bytes are staged.
- R8: All bytes are sent MSB first. Staged bytes follow the status byte in the order b0 then b1, and any byte requested beyond the staged data reads FFh.
- R9: Data-available and pair clear once the eighth bit of the last staged byte has been shifted out. A read that transfers only the status byte leaves them set.
- R10: If the master NACKs before the last staged byte, data-available stays set, and the next read sends the staged bytes again, starting from b0.
- R11: A repeated start begins a new address sequence. A two-byte command cut short by it is dropped without a strobe.
- R12: SDA is only ever pulled low. Its drive changes only while SCL is low, and it is released after the master NACKs.
- R13: After a stop, or after the final acknowledge of a command, the block stays silent until the next start and matching address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| cmd_valid_o | output | 1 | One-cycle strobe for a completed command |
| cmd_code_o | output | 8 | Command code of the completed command |
| cmd_data_o | output | 8 | Data byte of the completed command (00h if none) |
| core_idle_i | input | 1 | Core has finished the last command; sets ready again |
| load_i | input | 1 | Stage read data pulse |
| load_two_i | input | 1 | With `load_i`: stage two bytes instead of one |
| load_b0_i | input | 8 | First byte to stage |
| load_b1_i | input | 8 | Second byte to stage |

## Verification
The bench instantiates the block with target address 14h (7-bit), command-length selector bit 7 and a two-stage synchroniser, and it runs SCL with 14 system clocks per bit. With selector bit 7, commands split evenly into one-byte and two-byte codes, so random codes reach both acknowledge counts and the not-acknowledged extra byte. Because the bit period leaves several clocks between each SCL edge and the change of SDA, the bench can check from the pins that the block switches its drive only while SCL is low. Directed sequences cover the status-only read, the early NACK with replay, reads past the staged data, a repeated start in the middle of a command, and foreign addresses.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 4;
    localparam int RDY_BIT  = 7;
    localparam int DAV_BIT  = 6;
    localparam int PAIR_BIT = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WRX,
        ST_TX,
        ST_MACK
    } tgt_state_e;

    // Command length lookup: selected bit set means one data byte follows.
    function automatic logic takes_data(input logic [BYTE_W-1:0] code, input logic [2:0] sel);
        return code[sel];
    endfunction
endpackage

// File: rtl/i2c_line_sampler.sv
`timescale 1ns/1ps
module i2c_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_o      = scl_pipe[STAGES-1];
    assign sda_o      = sda_pipe[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_d;
    assign scl_fall_o = ~scl_o & scl_d;
    assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
    assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_out_stage.sv
`timescale 1ns/1ps
module i2c_out_stage
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              load_two_i,
    input  logic [BYTE_W-1:0] load_b0_i,
    input  logic [BYTE_W-1:0] load_b1_i,
    input  logic              clr_dav_i,
    input  logic              cmd_done_i,
    input  logic              core_idle_i,
    output logic [BYTE_W-1:0] status_o,
    output logic              dav_o,
    output logic              pair_o,
    output logic [BYTE_W-1:0] byte0_o,
    output logic [BYTE_W-1:0] byte1_o
);
    logic busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dav_o   <= 1'b0;
            pair_o  <= 1'b0;
            byte0_o <= '0;
            byte1_o <= '0;
            busy_q  <= 1'b0;
        end else begin
            if (load_i) begin
                byte0_o <= load_b0_i;
                byte1_o <= load_two_i ? load_b1_i : '0;
                dav_o   <= 1'b1;
                pair_o  <= load_two_i;
            end else if (clr_dav_i) begin
                dav_o  <= 1'b0;
                pair_o <= 1'b0;
            end
            if (cmd_done_i)       busy_q <= 1'b1;
            else if (core_idle_i) busy_q <= 1'b0;
        end
    end

    always_comb begin
        status_o           = '0;
        status_o[RDY_BIT]  = ~busy_q;
        status_o[DAV_BIT]  = dav_o;
        status_o[PAIR_BIT] = pair_o;
    end

    p_rdy_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_i |=> !status_o[RDY_BIT]);
    p_load_dav_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (dav_o && (pair_o == $past(load_two_i))));
    p_dav_clear_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dav_o) |-> $past(clr_dav_i));
endmodule

// File: rtl/i2c_cmd_target.sv
`timescale 1ns/1ps
module i2c_cmd_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR  = 7'h14,
    parameter logic [2:0] LONG_CMD_BIT = 3'd7,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic       cmd_valid_o,
    output logic [7:0] cmd_code_o,
    output logic [7:0] cmd_data_o,
    input  logic       core_idle_i,
    input  logic       load_i,
    input  logic       load_two_i,
    input  logic [7:0] load_b0_i,
    input  logic [7:0] load_b1_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    tgt_state_e        state, nxt;
    logic [BYTE_W-1:0] shreg, cmd_q, status, b0, b1, next_byte;
    logic [CNT_W-1:0]  bitcnt;
    logic [1:0]        tx_idx, last_idx, next_idx;
    logic              rd_mode, wr_last, byte_idx, nack_q, sda_oe_q, clr_dav;
    logic              dav, pair, addr_hit;

    i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    i2c_out_stage u_stage (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_two_i(load_two_i),
        .load_b0_i(load_b0_i), .load_b1_i(load_b1_i), .clr_dav_i(clr_dav),
        .cmd_done_i(cmd_valid_o), .core_idle_i(core_idle_i), .status_o(status),
        .dav_o(dav), .pair_o(pair), .byte0_o(b0), .byte1_o(b1)
    );

    assign addr_hit  = (shreg[7:1] == TARGET_ADDR);
    assign last_idx  = pair ? 2'd2 : 2'd1;
    assign next_idx  = tx_idx + 2'd1;
    assign next_byte = (dav && next_idx == 2'd1)         ? b0 :
                       (dav && pair && next_idx == 2'd2) ? b1 : 8'hFF;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = ST_IDLE;
            ST_ADDR: if (scl_fall && bitcnt == 4'd8) nxt = addr_hit ? ST_ACK : ST_IDLE;
            ST_ACK:  if (scl_fall) nxt = rd_mode ? ST_TX : (wr_last ? ST_IDLE : ST_WRX);
            ST_WRX:  if (scl_fall && bitcnt == 4'd8) nxt = ST_ACK;
            ST_TX:   if (scl_fall && bitcnt == 4'd7) nxt = ST_MACK;
            ST_MACK: if (scl_fall) nxt = nack_q ? ST_IDLE : ST_TX;
            default: nxt = ST_IDLE;
        endcase
        if (start_ev)     nxt = ST_ADDR;
        else if (stop_ev) nxt = ST_IDLE;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg       <= '0;
            cmd_q       <= '0;
            bitcnt      <= '0;
            tx_idx      <= '0;
            rd_mode     <= 1'b0;
            wr_last     <= 1'b0;
            byte_idx    <= 1'b0;
            nack_q      <= 1'b0;
            sda_oe_q    <= 1'b0;
            clr_dav     <= 1'b0;
            cmd_valid_o <= 1'b0;
            cmd_code_o  <= '0;
            cmd_data_o  <= '0;
        end else begin
            cmd_valid_o <= 1'b0;
            clr_dav     <= 1'b0;
            if (start_ev) begin
                bitcnt   <= '0;
                sda_oe_q <= 1'b0;
                rd_mode  <= 1'b0;
                wr_last  <= 1'b0;
                byte_idx <= 1'b0;
            end else if (stop_ev) begin
                sda_oe_q <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WRX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe_q <= 1'b1;
                                    rd_mode  <= shreg[0];
                                end
                            end else begin
                                sda_oe_q <= 1'b1;
                                if (!byte_idx) begin
                                    cmd_q <= shreg;
                                    if (!takes_data(shreg, LONG_CMD_BIT)) begin
                                        cmd_valid_o <= 1'b1;
                                        cmd_code_o  <= shreg;
                                        cmd_data_o  <= '0;
                                        wr_last     <= 1'b1;
                                    end else begin
                                        byte_idx <= 1'b1;
                                    end
                                end else begin
                                    cmd_valid_o <= 1'b1;
                                    cmd_code_o  <= cmd_q;
                                    cmd_data_o  <= shreg;
                                    wr_last     <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (rd_mode) begin
                            shreg    <= status;
                            sda_oe_q <= ~status[RDY_BIT];
                            tx_idx   <= '0;
                        end else begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_oe_q <= 1'b0;
                            bitcnt   <= '0;
                            if (dav && tx_idx == last_idx) clr_dav <= 1'b1;
                        end else begin
                            shreg    <= {shreg[6:0], 1'b1};
                            sda_oe_q <= ~shreg[6];
                            bitcnt   <= bitcnt + 4'd1;
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_s;
                        end else if (scl_fall && !nack_q) begin
                            shreg    <= next_byte;
                            sda_oe_q <= ~next_byte[7];
                            if (tx_idx != 2'd3) tx_idx <= next_idx;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o = sda_oe_q;

    p_sda_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_q) |-> !$past(scl_s));
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);
    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_q);
endmodule

// File: tb/i2c_cmd_target_tb.sv
`timescale 1ns/1ps
module i2c_cmd_target_tb_top;
    localparam int Q = 6;
    localparam int H = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic core_idle = 1'b0, load = 1'b0, load_two = 1'b0;
    logic [7:0] lb0 = '0, lb1 = '0;
    logic sda_oe, cmd_valid;
    logic [7:0] cmd_code, cmd_data;
    logic sda_bus;

    int checks = 0, errors = 0, strobes = 0, viol = 0;
    logic [7:0] last_code = '0, last_data = '0;
    logic oe_prev = 1'b0;
    logic [7:0] rd_buf [0:3];

    // bench model of the status and staging state
    bit m_busy = 0, m_dav = 0, m_pair = 0;
    logic [7:0] m_b0 = '0, m_b1 = '0;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_cmd_target #(.TARGET_ADDR(7'h14), .LONG_CMD_BIT(3'd7), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code), .cmd_data_o(cmd_data),
        .core_idle_i(core_idle), .load_i(load), .load_two_i(load_two),
        .load_b0_i(lb0), .load_b1_i(lb1)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            strobes++;
            last_code = cmd_code;
            last_data = cmd_data;
        end
        if (rst_n && (sda_oe != oe_prev) && scl_m) viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(H);
    endtask

    task automatic bus_rstart();
        sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(H);
    endtask

    task automatic bus_stop();
        sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl_m = 1; wq(Q); scl_m = 0; wq(H);
        end
        sda_m = 1; wq(Q); scl_m = 1; wq(3);
        acked = !sda_bus;
        wq(3); scl_m = 0; wq(H);
    endtask

    task automatic rbyte(input bit nack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl_m = 1; wq(3); b[i] = sda_bus; wq(3); scl_m = 0; wq(H);
        end
        sda_m = nack; wq(Q); scl_m = 1; wq(Q); scl_m = 0; wq(H); sda_m = 1;
    endtask

    function automatic logic [7:0] exp_status();
        return {~m_busy, m_dav, m_pair, 5'b0};
    endfunction

    function automatic int exp_len(input logic [7:0] code);
        return code[7] ? 2 : 1;
    endfunction

    // Read n bytes (status first), compare against the model, update the model.
    task automatic read_check(input int n, input string tag);
        bit a;
        int last;
        logic [7:0] e;
        bus_start();
        wbyte(8'h29, a);
        chk(a, "R2 read address ack", a, 1);
        for (int k = 0; k < n; k++) rbyte(k == n - 1, rd_buf[k]);
        chk(sda_oe == 1'b0, "R12 released after NACK", sda_oe, 0);
        bus_stop();
        chk(rd_buf[0] == exp_status(), {"R6 status ", tag}, rd_buf[0], exp_status());
        for (int k = 1; k < n; k++) begin
            e = (m_dav && k == 1) ? m_b0 : (m_dav && m_pair && k == 2) ? m_b1 : 8'hFF;
            chk(rd_buf[k] == e, {"R8 data ", tag}, rd_buf[k], e);
        end
        last = m_pair ? 2 : 1;
        if (m_dav && (n - 1) >= last) begin
            m_dav = 0;
            m_pair = 0;
        end
    endtask

    task automatic write_check(input logic [7:0] code, input logic [7:0] data, input int nbytes, input string tag);
        bit a;
        int acks = 0, s0, need;
        s0 = strobes;
        need = exp_len(code);
        bus_start();
        wbyte(8'h28, a);
        chk(a, "R2 write address ack", a, 1);
        for (int i = 0; i < nbytes; i++) begin
            wbyte(i == 0 ? code : (i == 1 ? data : 8'h5A), a);
            if (a) acks++;
        end
        bus_stop();
        chk(acks == ((nbytes < need) ? nbytes : need), {"R3 ack count ", tag}, acks, need);
        if (nbytes >= need) begin
            chk(strobes == s0 + 1, {"R4 one strobe ", tag}, strobes - s0, 1);
            chk(last_code == code, {"R4 code ", tag}, last_code, code);
            chk(last_data == (need == 2 ? data : 8'h00), {"R4 data ", tag}, last_data, need == 2 ? data : 8'h00);
            m_busy = 1;
        end else begin
            chk(strobes == s0, {"R13 no strobe on short command ", tag}, strobes - s0, 0);
        end
    endtask

    task automatic do_load(input bit two, input logic [7:0] a, input logic [7:0] b);
        load = 1; load_two = two; lb0 = a; lb1 = b; wq(1);
        load = 0; wq(2);
        m_dav = 1; m_pair = two; m_b0 = a; m_b1 = two ? b : 8'h00;
    endtask

    task automatic idle_pulse();
        core_idle = 1; wq(2); core_idle = 0; wq(2);
        m_busy = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog all requirements actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit a;
        int s0;
        void'($urandom(32'h5EED_1234));
        wq(4); rst_n = 1; wq(4);

        // R1 reset state
        chk(sda_oe == 1'b0, "R1 SDA released", sda_oe, 0);
        chk(strobes == 0, "R1 no strobe", strobes, 0);
        read_check(1, "R1 after reset");

        // R2 foreign addresses, followed bytes ignored
        s0 = strobes;
        bus_start(); wbyte(8'h50, a); chk(!a, "R2 foreign address", a, 0);
        wbyte(8'h15, a); chk(!a, "R2 byte after foreign address", a, 0);
        bus_stop();
        bus_start(); wbyte(8'h2A, a); chk(!a, "R2 neighbour address", a, 0);
        bus_stop();
        chk(strobes == s0, "R2 no strobe", strobes - s0, 0);

        // R3/R4 one-byte command with extra byte; R5 ready
        write_check(8'h15, 8'h00, 2, "one-byte+extra");
        read_check(1, "R5 busy");
        idle_pulse();
        read_check(1, "R5 ready again");
        write_check(8'h9C, 8'h3E, 3, "two-byte+extra");
        idle_pulse();

        // R11 repeated start mid-command, R13 stop mid-command
        s0 = strobes;
        bus_start(); wbyte(8'h28, a); wbyte(8'h85, a);
        bus_rstart(); wbyte(8'h28, a); chk(a, "R11 address after repeated start", a, 1);
        wbyte(8'h11, a); chk(a, "R11 command after repeated start", a, 1);
        bus_stop();
        chk(strobes == s0 + 1, "R11 only the completed command", strobes - s0, 1);
        chk(last_code == 8'h11, "R11 code", last_code, 8'h11);
        m_busy = 1; idle_pulse();
        write_check(8'h90, 8'h00, 1, "R13 stop before data");

        // R7/R9 single byte, status-only read keeps DAV
        do_load(0, 8'h5A, 8'h00);
        read_check(1, "R9 status only");
        read_check(1, "R9 still set");
        read_check(2, "R8 single byte");
        read_check(1, "R9 cleared");

        // R8 two bytes plus read past the end
        do_load(1, 8'hA1, 8'hB2);
        read_check(4, "R8 pair and past end");
        read_check(2, "R8 FF without data");

        // R10 early NACK and replay
        do_load(1, 8'h3C, 8'hC3);
        read_check(2, "R10 early nack");
        read_check(3, "R10 replay");
        read_check(1, "R9 after replay");

        // random mix
        for (int it = 0; it < 50; it++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) write_check(8'($urandom), 8'($urandom), 1 + int'($urandom % 3), "random write");
            else if (op == 1) do_load(1'($urandom), 8'($urandom), 8'($urandom));
            else if (op == 2) read_check(1 + int'($urandom % 4), "random read");
            else idle_pulse();
        end

        chk(viol == 0, "R12 SDA drive changed while SCL high", viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule